// File: doc/BRIEF.md
# Memory Domain Access Checker

This block decides, once per memory access, whether the access may proceed under the per-domain access settings. Each access presents three things: the 32-bit domain access control word, the 4-bit domain number of the translation entry that matched, and the pass/fail result of that entry's own access-permission check. The block picks out the two-bit code for that domain. The code decides whether the permission result is enforced, bypassed, or overridden by an unconditional fault.

The verdict is registered. One cycle after a valid request, the block raises a response valid together with exactly one of three flags: domain fault, permission fault or granted. Domains behave the same whatever the mapping granularity of the matched entry (section, large page or small page), so no granularity input exists. Page table walking, the TLB and the computation of the permission bits are handled elsewhere.

Top module: `domain_gate`

## Requirements
- R1: Domain n (0..15) is governed by bits [2n+1:2n] of `domainCtl`; domain 0 uses bits [1:0] and domain 15 uses bits [31:30].
- R2: Code 2'b00 (no access) gives a domain fault whatever the value of `permOk`.
- R3: Code 2'b01 (client) with `permOk` = 1 gives granted.
- R4: Code 2'b01 (client) with `permOk` = 0 gives a permission fault.
- R5: Code 2'b10 (reserved) gives a domain fault whatever the value of `permOk`.
- R6: Code 2'b11 (manager) gives granted whatever the value of `permOk`, and never a permission fault.
- R7: When `rspValid` is high, exactly one of `domainFault`, `permFault` and `granted` is high.
- R8: `rspValid` is high in the cycle after a cycle with `reqValid` high, and low otherwise. Back-to-back requests each get their own response.
- R9: After reset, and in every cycle with `rspValid` low, all three flags are 0.
- R10: The codes of domains other than the selected one have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access to be checked this cycle |
| domainCtl | input | 32 | Domain access control word, two bits per domain |
| domainId | input | 4 | Domain number of the matched entry |
| permOk | input | 1 | Entry permission check passed |
| rspValid | output | 1 | Verdict valid |
| domainFault | output | 1 | Access denied by the domain code |
| permFault | output | 1 | Client access that failed the permission check |
| granted | output | 1 | Access allowed |

## Verification
Every verdict and its `rspValid` are due exactly one clock edge after the request is sampled. The bench drives each request on a falling edge and holds it for one cycle. It reads the flags on the next falling edge, after the single register stage has captured them. It then reads them once more on the following falling edge, with no request pending, to confirm that the flags return to zero. Back-to-back requests are checked on consecutive falling edges, one response per request.

// File: rtl/domain_gate_pkg.sv
package domain_gate_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE   = 2'b00,
    CODE_CLIENT = 2'b01,
    CODE_RSVD   = 2'b10,
    CODE_MGR    = 2'b11
  } access_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } gate_strobe_t;

endpackage

// File: rtl/domain_gate_ctrl.sv
module domain_gate_ctrl
  import domain_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output gate_strobe_t strobe,
  output logic         rspValid
);

  always_comb begin
    strobe.capture = reqValid;
    strobe.clear   = !reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

endmodule

// File: rtl/domain_gate_dp.sv
module domain_gate_dp
  import domain_gate_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int CTL_W = NUM_DOMAINS * CODE_W,
  localparam int ID_W  = $clog2(NUM_DOMAINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  gate_strobe_t     strobe,
  input  logic [CTL_W-1:0] domainCtl,
  input  logic [ID_W-1:0]  domainId,
  input  logic             permOk,
  output logic             domainFault,
  output logic             permFault,
  output logic             granted
);

  logic [CODE_W-1:0] codeArr [NUM_DOMAINS];

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
    assign codeArr[g] = domainCtl[g*CODE_W +: CODE_W];
  end

  access_code_e selCode;
  logic nxtDomFault, nxtPermFault, nxtGranted;

  always_comb begin
    selCode      = access_code_e'(codeArr[domainId]);
    nxtDomFault  = 1'b0;
    nxtPermFault = 1'b0;
    nxtGranted   = 1'b0;
    unique case (selCode)
      CODE_NONE, CODE_RSVD: nxtDomFault = 1'b1;
      CODE_CLIENT: begin
        nxtGranted   = permOk;
        nxtPermFault = !permOk;
      end
      CODE_MGR: nxtGranted = 1'b1;
      default: nxtDomFault = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domainFault <= 1'b0;
      permFault   <= 1'b0;
      granted     <= 1'b0;
    end else if (strobe.capture) begin
      domainFault <= nxtDomFault;
      permFault   <= nxtPermFault;
      granted     <= nxtGranted;
    end else if (strobe.clear) begin
      domainFault <= 1'b0;
      permFault   <= 1'b0;
      granted     <= 1'b0;
    end
  end

endmodule

// File: rtl/domain_gate.sv
module domain_gate
  import domain_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] domainCtl,
  input  logic [3:0]  domainId,
  input  logic        permOk,
  output logic        rspValid,
  output logic        domainFault,
  output logic        permFault,
  output logic        granted
);

  gate_strobe_t strobe;

  domain_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  domain_gate_dp #(.NUM_DOMAINS(16)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .domainCtl   (domainCtl),
    .domainId    (domainId),
    .permOk      (permOk),
    .domainFault (domainFault),
    .permFault   (permFault),
    .granted     (granted)
  );

endmodule

// File: rtl/domain_gate_chk.sv
module domain_gate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] domainCtl,
  input logic [3:0]  domainId,
  input logic        permOk,
  input logic        rspValid,
  input logic        domainFault,
  input logic        permFault,
  input logic        granted
);

  logic [1:0] reqCode;
  assign reqCode = domainCtl[{domainId, 1'b0} +: 2];

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({domainFault, permFault, granted}) == 1); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(domainFault || permFault || granted)); // R9

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R8

  AST_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode == 2'b00) |=> domainFault); // R2

  AST_CLIENT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode == 2'b01 && permOk) |=> granted); // R3

  AST_CLIENT_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode == 2'b01 && !permOk) |=> permFault); // R4

  AST_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode == 2'b10) |=> domainFault); // R5

  AST_MANAGER: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCode == 2'b11) |=> (granted && !permFault)); // R6

endmodule

bind domain_gate domain_gate_chk u_chk (.*);

// File: tb/domain_gate_bench.sv
`timescale 1ns/1ps
module domain_gate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] domainCtl = '0;
  logic [3:0]  domainId = '0;
  logic        permOk = 1'b0;
  logic        rspValid, domainFault, permFault, granted;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  domain_gate u_domain_gate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .domainCtl(domainCtl),
    .domainId(domainId), .permOk(permOk), .rspValid(rspValid),
    .domainFault(domainFault), .permFault(permFault), .granted(granted)
  );

  // expected {valid, df, pf, g} from the requirements
  function automatic logic [3:0] expect_of(logic [1:0] code, logic ok);
    case (code)
      2'b00:   return 4'b1100;          // R2
      2'b10:   return 4'b1100;          // R5
      2'b01:   return ok ? 4'b1001 : 4'b1010; // R3 / R4
      default: return 4'b1001;          // R6
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {rspValid, domainFault, permFault, granted};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,df,pf,g} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one request on a falling edge, check verdict, then check idle
  task automatic access(string req, logic [31:0] ctl, logic [3:0] id, logic ok);
    domainCtl = ctl; domainId = id; permOk = ok; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, expect_of(ctl[id*2 +: 2], ok));
    @(negedge clk);
    check({req, " R9 idle"}, 4'b0000);
  endtask

  task automatic t_reset;
    check("R9 reset", 4'b0000);
  endtask

  task automatic t_codes;
    access("R2 none ok=1", 32'h0000_0000, 4'd3, 1'b1);
    access("R3 client pass", 32'h0000_0040, 4'd3, 1'b1);
    access("R4 client fail", 32'h0000_0040, 4'd3, 1'b0);
    access("R5 reserved ok=1", 32'h0000_0080, 4'd3, 1'b1);
    access("R6 manager ok=0", 32'h0000_00C0, 4'd3, 1'b0);
    access("R6 manager ok=1", 32'h0000_00C0, 4'd3, 1'b1);
  endtask

  task automatic t_fields;
    access("R1 domain0 client", 32'hFFFF_FFFD, 4'd0, 1'b0);
    access("R1 domain15 reserved", 32'h8000_0000, 4'd15, 1'b1);
    access("R1 domain15 manager", 32'hC000_0000, 4'd15, 1'b0);
  endtask

  task automatic t_isolation;
    access("R10 others manager", 32'hFFFF_F3FF, 4'd5, 1'b1);
    access("R10 others none", 32'h0000_0C00, 4'd5, 1'b0);
    access("R10 neighbour client", 32'hFFFF_F7FF, 4'd5, 1'b0);
  endtask

  task automatic t_back_to_back;
    domainCtl = 32'h0000_0007; permOk = 1'b0; // d0=11, d1=01
    domainId = 4'd0; reqValid = 1'b1;
    @(negedge clk);
    check("R8 b2b first", 4'b1001);
    domainId = 4'd1;
    @(negedge clk);
    check("R8 b2b second", 4'b1010);
    domainId = 4'd2;
    @(negedge clk);
    reqValid = 1'b0;
    check("R8 b2b third", 4'b1100);
    @(negedge clk);
    check("R8 end idle", 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    check("R8 no request", 4'b0000);
    t_codes();
    t_fields();
    t_isolation();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule